// File: doc/BRIEF.md
# Cycle-Driven Down-Counting Interrupt Timer

This block is a 16-bit interrupt timer that advances once per CPU cycle, as marked by a one-cycle tick enable. Software sets it up through three byte-wide write strobes that an address decoder outside the block produces. The count strobe fills the 16-bit counter one byte at a time. The control strobe arms or disarms the timer. The acknowledge strobe clears a pending interrupt.

While the timer is armed, each tick lowers the counter by one. A tick that finds the counter already at zero raises the pending flag, lets the counter wrap to all ones, and disarms the timer. The timer therefore fires once for each time software arms it. The interrupt line is a registered, active-high copy of the pending flag. The counter and the enable, pending and byte-select flags are also brought out so they can be inspected and saved.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the counter reads 0x0000, enable and pending are 0, the byte select points at the upper byte (`tgl_hi_q` = 1) and `irq` is 0.
- R2: Successive count-strobe writes alternate between the upper byte and the lower byte, starting with the upper byte. Each write replaces only its own byte: writing 0x12 then 0x34 gives 0x1234, and a later single write of 0xAB then gives 0xAB34.
- R3: Any control-strobe write returns the byte select to the upper byte (`tgl_hi_q` = 1), whatever the data.
- R4: A control-strobe write sets enable to the value of data bit 4. The other data bits have no effect: writing 0xEF disarms the timer and writing 0x10 arms it.
- R5: While enabled, each tick lowers the counter by one. Without a tick, or while disabled, the counter holds its value unless a count-strobe write occurs.
- R6: A tick that arrives while the timer is enabled and the counter is 0x0000 sets pending, and the counter wraps to 0xFFFF. After loading N and enabling, pending rises on exactly the (N+1)-th tick.
- R7: A firing tick clears enable, so later ticks neither change the counter nor fire again until the timer is re-enabled.
- R8: An acknowledge-strobe write clears pending, whatever the data. Otherwise pending stays set, including after the auto-disable.
- R9: `irq` follows pending. It rises in the cycle after the firing tick and falls in the cycle after the acknowledge.
- R10: When several events fall in the same cycle: a firing tick overrides an acknowledge, so pending ends up set; a control write overrides the auto-disable; a count write overrides the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-cycle CPU-cycle enable |
| wr_load | input | 1 | Count-strobe write (byte-alternating) |
| wr_ctrl | input | 1 | Control-strobe write |
| wr_ack | input | 1 | Acknowledge-strobe write |
| wdata | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high |
| cnt_q | output | 16 | Current counter value |
| en_q | output | 1 | Timer enable flag |
| pend_q | output | 1 | Pending flag |
| tgl_hi_q | output | 1 | 1 when the next count write targets the upper byte |

## Verification
The collision of most interest is a firing tick that lands in the same cycle as an acknowledge write. The firing tick must win, so the acknowledge cannot discard a new event. The bench provokes this directly by loading zero, enabling, and then driving the tick and the acknowledge together. The random phase also raises all three strobes and the tick at once, often enough to reach this case and the other two overlaps. Each cycle is judged against a bench model that applies the priority rules from the requirements: fire over acknowledge, control over auto-disable, and count write over decrement.

// File: rtl/cyc_irq_timer_pkg.sv
package cyc_irq_timer_pkg;

    localparam int BUS_W  = 8;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int EN_BIT = 4;

    typedef logic [BUS_W-1:0] byte_t;
    typedef logic [CNT_W-1:0] count_t;

    // Lane selected by the byte toggle
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Events seen in one cycle, derived at the top level
    typedef struct packed {
        logic dec;
        logic fire;
        logic load;
        logic ctrl;
        logic ack;
    } evt_t;

    function automatic count_t merge_lane(input count_t cur, input byte_t b, input lane_e lane);
        count_t r;
        r = cur;
        if (lane == LANE_HI) r[CNT_W-1:BUS_W] = b;
        else                 r[BUS_W-1:0]     = b;
        return r;
    endfunction

    function automatic logic is_zero(input count_t c);
        return (c == '0);
    endfunction

endpackage

// File: rtl/cyc_irq_load_seq.sv
module cyc_irq_load_seq
    import cyc_irq_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_load,
    input  logic   wr_ctrl,
    input  byte_t  wdata,
    input  count_t cnt_cur,
    output count_t ld_val,
    output logic   tgl_hi_q
);
    lane_e lane_q;
    lane_e lane_d;

    // Byte lanes: each lane either takes the write data or keeps the counter's byte
    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_comb begin
            if ((g == 1) == (lane_q == LANE_HI))
                ld_val[g*BUS_W +: BUS_W] = wdata;
            else
                ld_val[g*BUS_W +: BUS_W] = cnt_cur[g*BUS_W +: BUS_W];
        end
    end

    always_comb begin
        lane_d = lane_q;
        if (wr_ctrl)
            lane_d = LANE_HI;
        else if (wr_load)
            lane_d = (lane_q == LANE_HI) ? LANE_LO : LANE_HI;
    end

    always_ff @(posedge clk) begin
        if (rst) lane_q <= LANE_HI;
        else     lane_q <= lane_d;
    end

    assign tgl_hi_q = (lane_q == LANE_HI);

endmodule

// File: rtl/cyc_irq_downcnt.sv
module cyc_irq_downcnt
    import cyc_irq_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  count_t ld_val,
    input  logic   dec,
    output count_t cnt_q,
    output logic   zero
);
    count_t cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = ld_val;
        else if (dec) cnt_d = cnt_q - count_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero = is_zero(cnt_q);

endmodule

// File: rtl/cyc_irq_flags.sv
module cyc_irq_flags
    import cyc_irq_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  logic ctrl_en_bit,
    output logic en_q,
    output logic pend_q
);
    logic en_d;
    logic pend_d;

    always_comb begin
        en_d = en_q;
        if (evt.ctrl)      en_d = ctrl_en_bit;
        else if (evt.fire) en_d = 1'b0;
    end

    always_comb begin
        pend_d = pend_q;
        if (evt.fire)     pend_d = 1'b1;
        else if (evt.ack) pend_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_irq_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_tick,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             wr_ack,
    input  logic [BUS_W-1:0] wdata,
    output logic             irq,
    output logic [CNT_W-1:0] cnt_q,
    output logic             en_q,
    output logic             pend_q,
    output logic             tgl_hi_q
);
    evt_t   evt;
    count_t ld_val;
    logic   cnt_zero;

    always_comb begin
        evt.dec  = cyc_tick & en_q;
        evt.fire = cyc_tick & en_q & cnt_zero;
        evt.load = wr_load;
        evt.ctrl = wr_ctrl;
        evt.ack  = wr_ack;
    end

    cyc_irq_load_seq u_ld (
        .clk      (clk),
        .rst      (rst),
        .wr_load  (evt.load),
        .wr_ctrl  (evt.ctrl),
        .wdata    (wdata),
        .cnt_cur  (cnt_q),
        .ld_val   (ld_val),
        .tgl_hi_q (tgl_hi_q)
    );

    cyc_irq_downcnt u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (evt.load),
        .ld_val (ld_val),
        .dec    (evt.dec),
        .cnt_q  (cnt_q),
        .zero   (cnt_zero)
    );

    cyc_irq_flags u_flg (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .ctrl_en_bit (wdata[EN_BIT]),
        .en_q        (en_q),
        .pend_q      (pend_q)
    );

    assign irq = pend_q;

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk
    import cyc_irq_timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cyc_tick,
    input logic             wr_load,
    input logic             wr_ctrl,
    input logic             wr_ack,
    input logic             irq,
    input logic [CNT_W-1:0] cnt_q,
    input logic             en_q,
    input logic             pend_q,
    input logic             tgl_hi_q
);
    logic fire_now;
    assign fire_now = cyc_tick && en_q && (cnt_q == '0);

    assert_toggle_reset_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> tgl_hi_q);

    assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_load && !(cyc_tick && en_q)) |=> $stable(cnt_q));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (fire_now && !wr_load) |=> (cnt_q == {CNT_W{1'b1}}));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (!irq && !fire_now) |=> !irq);

    assert_auto_disable_R7: assert property (@(posedge clk) disable iff (rst)
        (fire_now && !wr_ctrl) |=> !en_q);

    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !fire_now) |=> !pend_q);

    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !wr_ack) |=> pend_q);

    assert_fire_over_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (fire_now && wr_ack) |=> irq);

endmodule

bind cyc_irq_timer cyc_irq_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_tick (cyc_tick),
    .wr_load  (wr_load),
    .wr_ctrl  (wr_ctrl),
    .wr_ack   (wr_ack),
    .irq      (irq),
    .cnt_q    (cnt_q),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .tgl_hi_q (tgl_hi_q)
);

// File: tb/cyc_irq_timer_tb.sv
`timescale 1ns/1ps
module cyc_irq_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_tick, wr_load, wr_ctrl, wr_ack;
    logic [7:0]  wdata;
    logic        irq, en_q, pend_q, tgl_hi_q;
    logic [15:0] cnt_q;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    // bench reference state
    logic [15:0] m_cnt;
    logic        m_en, m_pend, m_hi;

    always #2.5 clk = ~clk;

    cyc_irq_timer u_dut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .wr_load(wr_load),
        .wr_ctrl(wr_ctrl), .wr_ack(wr_ack), .wdata(wdata), .irq(irq),
        .cnt_q(cnt_q), .en_q(en_q), .pend_q(pend_q), .tgl_hi_q(tgl_hi_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Next state from the requirements (R2..R10)
    task automatic model_step(input logic t, input logic ld, input logic ct,
                              input logic ak, input logic [7:0] d);
        logic fire;
        logic [15:0] nc;
        logic ne, np, nh;
        fire = t && m_en && (m_cnt == 16'h0);
        nc = m_cnt;
        if (ld) begin
            if (m_hi) nc[15:8] = d; else nc[7:0] = d;
        end else if (t && m_en) nc = m_cnt - 16'd1;
        ne = ct ? d[4] : (fire ? 1'b0 : m_en);
        np = fire ? 1'b1 : (ak ? 1'b0 : m_pend);
        nh = ct ? 1'b1 : (ld ? ~m_hi : m_hi);
        m_cnt = nc; m_en = ne; m_pend = np; m_hi = nh;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " cnt"}, 32'(cnt_q), 32'(m_cnt));
        chk({tag, " en"}, 32'(en_q), 32'(m_en));
        chk({tag, " pend"}, 32'(pend_q), 32'(m_pend));
        chk({tag, " tgl"}, 32'(tgl_hi_q), 32'(m_hi));
        chk({tag, " irq R9"}, 32'(irq), 32'(m_pend));
    endtask

    task automatic step(input logic t, input logic ld, input logic ct,
                        input logic ak, input logic [7:0] d);
        @(negedge clk);
        cyc_tick = t; wr_load = ld; wr_ctrl = ct; wr_ack = ak; wdata = d;
        @(posedge clk);
        model_step(t, ld, ct, ak, d);
        @(negedge clk);
        cyc_tick = 0; wr_load = 0; wr_ctrl = 0; wr_ack = 0; wdata = 8'h00;
    endtask

    task automatic arm_with(input logic [15:0] n);
        step(0, 0, 1, 0, 8'h00);
        step(0, 1, 0, 0, n[15:8]);
        step(0, 1, 0, 0, n[7:0]);
        step(0, 0, 1, 0, 8'h10);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int ticks;
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        rst = 1; cyc_tick = 0; wr_load = 0; wr_ctrl = 0; wr_ack = 0; wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_cnt = 0; m_en = 0; m_pend = 0; m_hi = 1;
        check_all("R1 reset");

        // R2: high then low, then byte preservation
        step(0, 1, 0, 0, 8'h12);
        step(0, 1, 0, 0, 8'h34);
        chk("R2 0x1234", 32'(cnt_q), 32'h1234);
        step(0, 1, 0, 0, 8'hAB);
        chk("R2 keep low", 32'(cnt_q), 32'hAB34);

        // R3: control write resets toggle
        step(0, 0, 1, 0, 8'h00);
        chk("R3 toggle hi", 32'(tgl_hi_q), 32'd1);
        step(0, 1, 0, 0, 8'h56);
        step(0, 1, 0, 0, 8'h78);
        chk("R3 0x5678", 32'(cnt_q), 32'h5678);

        // R4: only bit 4 matters
        step(0, 0, 1, 0, 8'hEF);
        chk("R4 0xEF disarms", 32'(en_q), 32'd0);
        step(1, 0, 0, 0, 8'h00);
        chk("R5 disabled holds", 32'(cnt_q), 32'h5678);
        step(0, 0, 1, 0, 8'h10);
        chk("R4 0x10 arms", 32'(en_q), 32'd1);
        step(1, 0, 0, 0, 8'h00);
        chk("R5 decrement", 32'(cnt_q), 32'h5677);

        // R6/R7: load 5, fire on 6th tick
        arm_with(16'd5);
        ticks = 0;
        for (int i = 0; i < 10 && !pend_q; i++) begin
            step(1, 0, 0, 0, 8'h00);
            ticks++;
        end
        chk("R6 N+1 ticks", 32'(ticks), 32'd6);
        chk("R6 wrap", 32'(cnt_q), 32'hFFFF);
        chk("R7 auto-disable", 32'(en_q), 32'd0);
        chk("R9 irq up", 32'(irq), 32'd1);
        repeat (4) step(1, 0, 0, 0, 8'h00);
        chk("R7 no further count", 32'(cnt_q), 32'hFFFF);
        chk("R8 pend held", 32'(pend_q), 32'd1);

        // R8: ack with arbitrary data
        step(0, 0, 0, 1, 8'h5A);
        chk("R8 ack clears", 32'(pend_q), 32'd0);
        chk("R9 irq down", 32'(irq), 32'd0);

        // R10: fire beats ack
        arm_with(16'd0);
        step(1, 0, 0, 1, 8'h00);
        chk("R10 fire over ack", 32'(pend_q), 32'd1);
        step(0, 0, 0, 1, 8'h00);
        // R10: ctrl beats auto-disable
        arm_with(16'd0);
        step(1, 0, 1, 0, 8'h10);
        chk("R10 ctrl over disable", 32'(en_q), 32'd1);
        chk("R10 pend on ctrl fire", 32'(pend_q), 32'd1);
        // R10: load beats decrement
        arm_with(16'h0300);
        step(1, 1, 0, 0, 8'h09);
        chk("R10 load over dec", 32'(cnt_q), 32'h0900);
        check_all("R10 model");

        // random phase, small counts so firing happens
        step(0, 0, 0, 1, 8'h00);
        for (int i = 0; i < 3000; i++) begin
            logic t, ld, ct, ak;
            logic [7:0] d;
            t  = ($urandom % 4) != 0;
            ld = ($urandom % 8) == 0;
            ct = ($urandom % 10) == 0;
            ak = ($urandom % 12) == 0;
            d  = 8'($urandom % 6);
            if ($urandom % 3 == 0) d = 8'($urandom);
            step(t, ld, ct, ak, d);
            check_all("R5/R6/R10 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule